// File: doc/BRIEF.md
# Serial Control Port with Programmable Bit Clock

This block is the control port of a converter-style peripheral. It acts as clock master on a three-wire synchronous serial link. It derives the serial bit clock from the master clock through a 10-bit divider. When the rate value is zero, the divider is bypassed and the master clock itself drives the pin. A host shifts 16-bit command words in on one data line, each word announced by an input frame-sync pulse. The port answers read commands with a framed word on a separate output data line, announced by its own output frame sync.

Commands either write a 10-bit value into one of eight internal registers, or ask for one register to be sent back. Register 0 holds the divider rate. A new rate is adopted only when no word is moving in or out, and only at a rising clock edge, so no phase of the serial clock is ever cut short. An enable input gates the whole port and releases the three driven pins through separate output-enable signals. A synchronous reset returns every register to zero, which leaves the serial clock at full master-clock speed.

Top module: `serctl_port`

## Requirements
- R1: With a nonzero rate value N in register 0, the serial clock has a period of 2*N master-clock cycles, made of N cycles high and N cycles low.
- R2: With a rate value of 0, the serial clock follows the master clock, with one serial period per master-clock cycle.
- R3: A command word starts when the input frame sync is seen high at a falling serial-clock edge. The 16 following falling edges capture the word most significant bit first. Bit 15 is the read flag (1 = read), bits 14:12 the register address, bits 11:10 a tag, and bits 9:0 the data.
- R4: A write command (bit 15 = 0) stores its data field into the addressed register. Its tag bits have no effect on the stored value.
- R5: A read command is answered from the first rising edge after its last bit. The output frame sync is high for exactly one serial period, and then 16 bits follow on successive rising edges, MSB first. The answer word is {1, address, tag of the read command, register contents}. The output data line is low while the frame sync is high.
- R6: The output data and output frame sync change only at rising serial-clock edges, and they hold steady through each low phase.
- R7: An input frame-sync pulse that arrives while a command word is still being shifted in is ignored, and the word in progress completes normally.
- R8: A rate written to register 0 takes effect at the first rising edge at which no command is being received and no answer is pending or being sent. The low phase in progress completes at the old rate.
- R9: With the port enable low, the serial clock, output data and output frame-sync enables are all low. Commands sent in this state are discarded, and the registers keep their contents.
- R10: A synchronous reset clears all registers, sets the rate to 0, and drives the output data and output frame sync low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Port enable; low releases the outputs and stops the port |
| sdi | input | 1 | Serial command data in |
| sdi_fs | input | 1 | Input frame sync |
| sclk | output | 1 | Serial bit clock |
| sclk_oe | output | 1 | Drive enable for sclk |
| sdo | output | 1 | Serial answer data out |
| sdo_oe | output | 1 | Drive enable for sdo |
| sdo_fs | output | 1 | Output frame sync |
| sdo_fs_oe | output | 1 | Drive enable for sdo_fs |

## Verification
Every register is written and read back at the pass-through rate and at a divided rate, using address-dependent data patterns. This shows that address decode works and that the capture and launch points stay aligned in both clocking modes. Rate values 1, 2, 3, 4 and 7 are each followed by a measurement of the serial period and the high phase, which separates a correct divider from an off-by-one count. A rate change from 3 to 5 checks that the adoption is deferred by timing the low phase that straddles the write. Further cases cover: a write with the tag bits set, a stray frame sync injected mid-word, a command sent with the port disabled, and a reset issued after the registers hold data. Each of these is checked by reading the affected register back through the port.

// File: rtl/serctl_port.sv
`timescale 1ns/1ps
module serctl_port #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic port_en,
  input  logic sdi,
  input  logic sdi_fs,
  output logic sclk,
  output logic sclk_oe,
  output logic sdo,
  output logic sdo_oe,
  output logic sdo_fs,
  output logic sdo_fs_oe
);
  localparam int TAG_W  = 2;
  localparam int WORD_W = 1 + ADDR_W + TAG_W + DATA_W;
  localparam int NREG   = 1 << ADDR_W;
  localparam int RXC_W  = $clog2(WORD_W);
  localparam int TXC_W  = $clog2(WORD_W + 1);
  localparam logic [RXC_W-1:0] RX_LAST = RXC_W'(WORD_W - 1);
  localparam logic [TXC_W-1:0] TX_LAST = TXC_W'(WORD_W);

  logic [DATA_W-1:0] rate_q, cnt_q;
  logic              sclk_q;
  logic [DATA_W-1:0] regs [NREG];

  logic              rx_busy;
  logic [RXC_W-1:0]  rx_cnt;
  logic [WORD_W-2:0] rx_sh;

  logic              tx_act;
  logic [TXC_W-1:0]  tx_cnt;
  logic [WORD_W-1:0] tx_sh;
  logic              sdo_q, fs_q;
  logic              pend_q;
  logic [WORD_W-1:0] pend_w;

  logic              div_on, tc, fall_ev, rise_ev, swap, done;
  logic [WORD_W-1:0] word;
  logic              rd_flag;
  logic [ADDR_W-1:0] w_addr;
  logic [TAG_W-1:0]  w_tag;
  logic [DATA_W-1:0] w_data;

  assign div_on  = |rate_q;
  assign tc      = cnt_q == rate_q - 1'b1;
  assign fall_ev = !div_on || (tc && sclk_q);
  assign rise_ev = !div_on || (tc && !sclk_q);
  assign swap    = rise_ev && !rx_busy && !tx_act && !pend_q;

  assign word = {rx_sh, sdi};
  assign {rd_flag, w_addr, w_tag, w_data} = word;
  assign done = port_en && fall_ev && rx_busy && rx_cnt == RX_LAST;

  // divider: a new rate is adopted only on an idle rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (swap) begin
      rate_q <= regs[0];
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!div_on) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tc) begin
      cnt_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      rx_busy <= 1'b0;
      rx_cnt  <= '0;
      rx_sh   <= '0;
    end else if (fall_ev) begin
      if (!rx_busy) begin
        rx_busy <= sdi_fs;
        rx_cnt  <= '0;
      end else begin
        rx_sh  <= {rx_sh[WORD_W-3:0], sdi};
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == RX_LAST) rx_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (done && !rd_flag) begin
      regs[w_addr] <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      pend_q <= 1'b0;
      pend_w <= '0;
    end else begin
      if (rise_ev && !tx_act) pend_q <= 1'b0;
      if (done && rd_flag) begin
        pend_q <= 1'b1;
        pend_w <= {1'b1, w_addr, w_tag, regs[w_addr]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      tx_act <= 1'b0;
      tx_cnt <= '0;
      tx_sh  <= '0;
      sdo_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else if (rise_ev) begin
      if (!tx_act) begin
        if (pend_q) begin
          tx_act <= 1'b1;
          tx_sh  <= pend_w;
          tx_cnt <= '0;
          fs_q   <= 1'b1;
          sdo_q  <= 1'b0;
        end
      end else begin
        fs_q <= 1'b0;
        if (tx_cnt == TX_LAST) begin
          tx_act <= 1'b0;
          sdo_q  <= 1'b0;
        end else begin
          sdo_q  <= tx_sh[WORD_W-1];
          tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  assign sclk      = div_on ? sclk_q : clk;
  assign sclk_oe   = port_en;
  assign sdo       = sdo_q;
  assign sdo_oe    = port_en;
  assign sdo_fs    = fs_q;
  assign sdo_fs_oe = port_en;
endmodule

// File: rtl/serctl_port_chk.sv
`timescale 1ns/1ps
module serctl_port_chk #(
  parameter int DATA_W = 10,
  parameter int RXC_W  = 4,
  parameter int RX_END = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              port_en,
  input logic              sdo,
  input logic              sdo_fs,
  input logic              sclk_q,
  input logic [DATA_W-1:0] rate_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              rx_busy,
  input logic [RXC_W-1:0]  rx_cnt,
  input logic              tx_act,
  input logic              pend_q
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rate_q != '0) |-> (cnt_q < rate_q)); // R1

  AST_FS_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
    sdo_fs |-> !sdo); // R5

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ((rate_q != '0) && !$stable(sdo)) |-> (sclk_q || !$past(port_en))); // R6

  AST_FS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ((rate_q != '0) && !$stable(sdo_fs)) |-> (sclk_q || !$past(port_en))); // R6

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (rx_busy && port_en && rx_cnt != RXC_W'(RX_END)) |=> rx_busy); // R7

  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rx_busy || tx_act || pend_q) |=> $stable(rate_q)); // R8

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!sdo && !sdo_fs && !tx_act)); // R9
endmodule

bind serctl_port serctl_port_chk #(
  .DATA_W(DATA_W),
  .RXC_W (RXC_W),
  .RX_END(WORD_W - 1)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .port_en(port_en),
  .sdo    (sdo),
  .sdo_fs (sdo_fs),
  .sclk_q (sclk_q),
  .rate_q (rate_q),
  .cnt_q  (cnt_q),
  .rx_busy(rx_busy),
  .rx_cnt (rx_cnt),
  .tx_act (tx_act),
  .pend_q (pend_q)
);

// File: tb/serctl_port_test.sv
`timescale 1ns/1ps
module serctl_port_test;
  localparam int CP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b1;
  logic sdi = 1'b0;
  logic sdi_fs = 1'b0;
  logic sclk, sclk_oe, sdo, sdo_oe, sdo_fs, sdo_fs_oe;

  int tests = 0;
  int fails = 0;
  int cur_rate = 0;
  logic [9:0] model [8];

  always #(CP/2) clk = !clk;

  serctl_port uut (
    .clk(clk), .rst(rst), .port_en(port_en), .sdi(sdi), .sdi_fs(sdi_fs),
    .sclk(sclk), .sclk_oe(sclk_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdo_fs(sdo_fs), .sdo_fs_oe(sdo_fs_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic rw, input logic [2:0] a, input logic [1:0] tg,
                      input logic [9:0] d, input int fs_at);
    logic [15:0] w;
    w = {rw, a, tg, d};
    @(posedge sclk); #1 sdi_fs = 1'b1; sdi = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(posedge sclk); #1 sdi_fs = (i == fs_at); sdi = w[15-i];
    end
  endtask

  task automatic get_word(output logic [15:0] w, output logic ok);
    ok = 1'b0;
    w = '0;
    for (int k = 0; k < 6 && !ok; k++) begin
      @(negedge sclk); #1;
      if (sdo_fs) ok = 1'b1;
    end
    sdi_fs = 1'b0;
    if (ok) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge sclk); #1;
        w[15-i] = sdo;
        if (i == 0) chk("R5 frame sync one period", {31'd0, sdo_fs}, 32'd0);
        if (cur_rate > 0 && i < 3) begin
          #(cur_rate*CP - 2);
          chk("R6 data held through low phase", {31'd0, sdo}, {31'd0, w[15-i]});
        end
      end
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge sclk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d, input logic [1:0] tg);
    send(1'b0, a, tg, d, -1);
    settle();
    model[a] = d;
    if (a == 3'd0) cur_rate = int'(d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] tg, input string tag);
    logic [15:0] w;
    logic ok;
    send(1'b1, a, tg, 10'd0, -1);
    get_word(w, ok);
    chk({tag, " answer frame seen"}, {31'd0, ok}, 32'd1);
    chk(tag, {16'd0, w}, {16'd0, 1'b1, a, tg, model[a]});
    settle();
  endtask

  task automatic meas(input string tag);
    time ta, tb, tc;
    @(posedge sclk); ta = $time;
    @(negedge sclk); tb = $time;
    @(posedge sclk); tc = $time;
    if (cur_rate == 0) begin
      chk({tag, " period"}, 32'(tc - ta), 32'(CP));
      chk({tag, " high"}, 32'(tb - ta), 32'(CP/2));
    end else begin
      chk({tag, " period"}, 32'(tc - ta), 32'(2*cur_rate*CP));
      chk({tag, " high"}, 32'(tb - ta), 32'(cur_rate*CP));
    end
    #1;
  endtask

  initial begin
    #(CP*150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    time t0, t1, t2;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset state
    chk("R10 sdo low after reset", {31'd0, sdo}, 32'd0);
    chk("R10 sdo_fs low after reset", {31'd0, sdo_fs}, 32'd0);
    chk("R9 enables high when on", {29'd0, sclk_oe, sdo_oe, sdo_fs_oe}, 32'd7);
    meas("R2 pass-through clock");
    for (int a = 0; a < 8; a++) rd(3'(a), 2'b00, "R10 register cleared");

    // R3 R4 R5: sweep all registers at pass-through and divided rates
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) wr(3'd0, 10'd2, 2'b00);
      for (int a = 1; a < 8; a++)
        wr(3'(a), 10'((a*137 + pass*59 + 5) & 10'h3ff), 2'b00);
      for (int a = 0; a < 8; a++)
        rd(3'(a), 2'(a), "R3 R5 readback");
    end

    // R1 divider sweep
    foreach (model[i]) begin end
    for (int k = 0; k < 5; k++) begin
      int r;
      r = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 4 : 7;
      wr(3'd0, 10'(r), 2'b00);
      meas("R1 divided clock");
      rd(3'd0, 2'b11, "R1 rate readback");
    end

    // R8 deferred rate change, 3 -> 5
    wr(3'd0, 10'd3, 2'b00);
    send(1'b0, 3'd0, 2'b00, 10'd5, -1);
    @(negedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    chk("R8 low phase keeps old rate", 32'(t1 - t0), 32'(3*CP));
    chk("R8 next period uses new rate", 32'(t2 - t1), 32'(10*CP));
    #1;
    model[0] = 10'd5;
    cur_rate = 5;
    settle();
    meas("R8 R1 new rate steady");

    // R4 tag bits of a write ignored
    wr(3'd3, 10'h2a5, 2'b11);
    rd(3'd3, 2'b00, "R4 tag ignored on write");

    // R7 stray frame sync mid-word
    send(1'b0, 3'd6, 2'b00, 10'h1c3, 4);
    settle();
    model[6] = 10'h1c3;
    rd(3'd6, 2'b01, "R7 stray sync ignored");
    rd(3'd5, 2'b10, "R7 port still in step");

    // R9 disabled port
    wr(3'd0, 10'd1, 2'b00);
    @(posedge clk); #1 port_en = 1'b0;
    chk("R9 enables low when off", {29'd0, sclk_oe, sdo_oe, sdo_fs_oe}, 32'd0);
    send(1'b0, 3'd2, 2'b00, 10'h3ff, -1);
    settle();
    chk("R9 sdo quiet when off", {30'd0, sdo, sdo_fs}, 32'd0);
    @(posedge clk); #1 port_en = 1'b1;
    settle();
    rd(3'd2, 2'b00, "R9 write discarded while off");

    // R10 reset with data held
    wr(3'd0, 10'd4, 2'b00);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    cur_rate = 0;
    chk("R10 sdo low after second reset", {30'd0, sdo, sdo_fs}, 32'd0);
    meas("R10 R2 rate back to zero");
    for (int a = 0; a < 8; a++) rd(3'(a), 2'b01, "R10 registers cleared again");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule